// File: doc/BRIEF.md
# Divided Subsystem Clock and Ordered Reset Release

This block produces the timing reference for a slower subsystem that runs from a fast system clock. Software writes a control word holding two divide fields, a divider run bit, a generation enable bit and two reset-release requests. The block turns the product of the two divide fields into a one-cycle clock-enable pulse, `div_tick`. Downstream logic uses that pulse as its divided clock.

The block also drives two active-low resets. One is for the PHY-side logic and one is for the subsystem-side logic. It releases them in a fixed order. The PHY-side reset deasserts only after a minimum number of divided clock periods. The subsystem-side reset then waits a further, longer settling delay counted in divided clock periods. In a real chip that delay would correspond to several milliseconds; here it is a parameter. A release request that arrives before the earlier stage has finished stays pending. Once a reset is released it stays released until core reset. The divide fields can be read back.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake. A write takes effect on the clock edge where `cfg_we` is high.

Top module: `subsys_clk_seq`

## Requirements
- R1: The divide ratio is N = (H + 1) * (L + 1), where L is the 3-bit low field and H is the implemented part of the 2-bit high field. While running, `div_tick` is high for exactly one cycle every N cycles. With N = 1 it is high on every cycle.
- R2: The readback `rd_div_lo` returns the stored low field. `rd_div_hi` returns the stored high field, except that its bit 1 is unimplemented and always reads 0. That bit also never contributes to the ratio, so a high field of 2 acts as 0 and 3 acts as 1.
- R3: A write updates the divide fields only if the stored run bit is 0 at the moment of the write. Any other write leaves the readback and the tick period unchanged.
- R4: While the stored run bit is 0, or while core reset `rst_n` is low, the divider is held cleared and `div_tick` stays low.
- R5: While the stored enable bit is 0, no `div_tick` pulse is produced.
- R6: After a write with `cfg_phy_go` = 1, `phy_rst_n` rises once PHY_WAIT ticks (default 6) have been counted. Only ticks that occur after the request is latched are counted. The rise happens on the edge that consumes the last of those ticks.
- R7: After a write with `cfg_sub_go` = 1, `sub_rst_n` rises once SUB_WAIT ticks (default 24) have been counted. Only ticks that occur while `phy_rst_n` is already high are counted. A request made before the PHY-side release stays pending, and `sub_rst_n` never rises ahead of `phy_rst_n`.
- R8: Once either reset output is high, it stays high. Later writes of 0 to the requests, to run or to enable do not lower it. Only core reset lowers it.
- R9: While `rst_n` is low, and immediately after reset, the outputs are as follows: `div_tick`, `phy_rst_n` and `sub_rst_n` are 0, and both readback fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous core reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_div_lo | input | 3 | Low divide field L |
| cfg_div_hi | input | 2 | High divide field H (bit 1 unimplemented) |
| cfg_div_run | input | 1 | Divider run bit; 0 holds the divider cleared and opens the divide fields for writing |
| cfg_clk_en | input | 1 | Divided clock generation enable |
| cfg_phy_go | input | 1 | Request to release the PHY-side reset (sticky) |
| cfg_sub_go | input | 1 | Request to release the subsystem-side reset (sticky) |
| div_tick | output | 1 | One-cycle divided clock-enable pulse |
| phy_rst_n | output | 1 | PHY-side reset, active low |
| sub_rst_n | output | 1 | Subsystem-side reset, active low |
| rd_div_lo | output | 3 | Readback of stored low field |
| rd_div_hi | output | 2 | Readback of stored high field |

## Verification
A write that sets run and enable is captured on its edge. The first `div_tick` is then visible N cycles later and repeats every N cycles. The bench therefore waits for one pulse and measures the gap to the next, rather than assuming a phase. The readback fields change on the edge that captures the write. Each reset output rises on the edge that consumes the tick completing its count, so it is first seen one cycle after that tick. The bench samples every output on the falling clock edge. It counts only ticks seen after a request has been latched, and it checks both the final count and that the tick sample came just before the rise.

// File: rtl/subsys_clk_pkg.sv
package subsys_clk_pkg;
  localparam int DIV_LO_W = 3;
  localparam int DIV_HI_W = 2;

  typedef struct packed {
    logic [DIV_HI_W-1:0] hi;
    logic [DIV_LO_W-1:0] lo;
    logic                run;
    logic                en;
  } div_cfg_t;
endpackage

// File: rtl/subsys_clk_cfg.sv
module subsys_clk_cfg
  import subsys_clk_pkg::*;
#(
  parameter int HI_IMPL = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  div_cfg_t wr,
  output div_cfg_t cur
);
  localparam logic [DIV_HI_W-1:0] HI_KEEP = DIV_HI_W'((1 << HI_IMPL) - 1);

  div_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.run <= wr.run;
      cfg_q.en  <= wr.en;
      // divide fields are open only while the divider is parked
      if (!cfg_q.run) begin
        cfg_q.lo <= wr.lo;
        cfg_q.hi <= wr.hi & HI_KEEP;
      end
    end
  end

  assign cur = cfg_q;
endmodule

// File: rtl/subsys_clk_div.sv
module subsys_clk_div
  import subsys_clk_pkg::*;
#(
  parameter int HI_IMPL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                en,
  input  logic [DIV_LO_W-1:0] lo,
  input  logic [DIV_HI_W-1:0] hi,
  output logic                tick
);
  localparam int RATIO_MAX = (1 << HI_IMPL) * (1 << DIV_LO_W);
  localparam int CNT_W     = (RATIO_MAX > 1) ? $clog2(RATIO_MAX) : 1;

  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_comb begin
    ratio = ((CNT_W+1)'(hi) + (CNT_W+1)'(1)) * ((CNT_W+1)'(lo) + (CNT_W+1)'(1));
    last  = CNT_W'(ratio - (CNT_W+1)'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (en) begin
      if (cnt_q >= last) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/subsys_rst_stage.sv
module subsys_rst_stage #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic arm,
  input  logic step,
  output logic released
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [W-1:0] FINAL = W'(LIMIT - 1);

  logic         req_q;
  logic [W-1:0] cnt_q;
  logic         rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      if (req_set) req_q <= 1'b1;
      if (req_q && arm && step && !rel_q) begin
        cnt_q <= cnt_q + W'(1);
        if (cnt_q == FINAL) rel_q <= 1'b1;
      end
    end
  end

  assign released = rel_q;
endmodule

// File: rtl/subsys_clk_seq.sv
module subsys_clk_seq
  import subsys_clk_pkg::*;
#(
  parameter int HI_IMPL  = 1,
  parameter int PHY_WAIT = 6,
  parameter int SUB_WAIT = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [DIV_LO_W-1:0] cfg_div_lo,
  input  logic [DIV_HI_W-1:0] cfg_div_hi,
  input  logic                cfg_div_run,
  input  logic                cfg_clk_en,
  input  logic                cfg_phy_go,
  input  logic                cfg_sub_go,
  output logic                div_tick,
  output logic                phy_rst_n,
  output logic                sub_rst_n,
  output logic [DIV_LO_W-1:0] rd_div_lo,
  output logic [DIV_HI_W-1:0] rd_div_hi
);
  localparam int NSTAGE = 2;

  div_cfg_t wr_word, cfg_cur;
  logic     cfg_run_q, cfg_en_q;
  logic [NSTAGE-1:0] stage_req, stage_arm, stage_rel;

  always_comb begin
    wr_word.lo  = cfg_div_lo;
    wr_word.hi  = cfg_div_hi;
    wr_word.run = cfg_div_run;
    wr_word.en  = cfg_clk_en;
  end

  subsys_clk_cfg #(.HI_IMPL(HI_IMPL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr(wr_word), .cur(cfg_cur)
  );

  assign cfg_run_q = cfg_cur.run;
  assign cfg_en_q  = cfg_cur.en;

  subsys_clk_div #(.HI_IMPL(HI_IMPL)) u_div (
    .clk(clk), .rst_n(rst_n), .run(cfg_run_q), .en(cfg_en_q),
    .lo(cfg_cur.lo), .hi(cfg_cur.hi), .tick(div_tick)
  );

  assign stage_req[0] = cfg_we && cfg_phy_go;
  assign stage_req[1] = cfg_we && cfg_sub_go;
  assign stage_arm[0] = 1'b1;
  assign stage_arm[1] = stage_rel[0];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int LIM = (s == 0) ? PHY_WAIT : SUB_WAIT;
    subsys_rst_stage #(.LIMIT(LIM)) u_stage (
      .clk(clk), .rst_n(rst_n), .req_set(stage_req[s]), .arm(stage_arm[s]),
      .step(div_tick), .released(stage_rel[s])
    );
  end

  assign phy_rst_n = stage_rel[0];
  assign sub_rst_n = stage_rel[1];
  assign rd_div_lo = cfg_cur.lo;
  assign rd_div_hi = cfg_cur.hi;
endmodule

// File: rtl/subsys_clk_seq_chk.sv
module subsys_clk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_run_q,
  input logic       cfg_en_q,
  input logic       div_tick,
  input logic       phy_rst_n,
  input logic       sub_rst_n,
  input logic [2:0] rd_div_lo,
  input logic [1:0] rd_div_hi
);
  AST_HI_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_div_hi[1] == 1'b0); // R2
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_run_q) |=> ($stable(rd_div_lo) && $stable(rd_div_hi))); // R3
  AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_run_q |=> !div_tick); // R4
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_q |=> !div_tick); // R5
  AST_PHY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> $past(div_tick)); // R6
  AST_SUB_AFTER_PHY: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst_n |-> phy_rst_n); // R7
  AST_PHY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst_n |=> phy_rst_n); // R8
  AST_SUB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sub_rst_n |=> sub_rst_n); // R8
endmodule

bind subsys_clk_seq subsys_clk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run_q(cfg_run_q),
  .cfg_en_q(cfg_en_q), .div_tick(div_tick), .phy_rst_n(phy_rst_n),
  .sub_rst_n(sub_rst_n), .rd_div_lo(rd_div_lo), .rd_div_hi(rd_div_hi)
);

// File: tb/subsys_clk_seq_test.sv
module subsys_clk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PHY_WAIT = 6;
  localparam int SUB_WAIT = 24;
  localparam int NV = 6;
  localparam int V_LO [NV] = '{0, 2, 7, 3, 1, 5};
  localparam int V_HI [NV] = '{0, 0, 1, 2, 1, 3};
  localparam int V_RH [NV] = '{0, 0, 1, 0, 1, 1};
  localparam int V_N  [NV] = '{1, 3, 16, 4, 4, 12};

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [2:0] cfg_div_lo = 0;
  logic [1:0] cfg_div_hi = 0;
  logic cfg_div_run = 0, cfg_clk_en = 0, cfg_phy_go = 0, cfg_sub_go = 0;
  logic div_tick, phy_rst_n, sub_rst_n;
  logic [2:0] rd_div_lo;
  logic [1:0] rd_div_hi;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subsys_clk_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div_lo(cfg_div_lo),
    .cfg_div_hi(cfg_div_hi), .cfg_div_run(cfg_div_run), .cfg_clk_en(cfg_clk_en),
    .cfg_phy_go(cfg_phy_go), .cfg_sub_go(cfg_sub_go), .div_tick(div_tick),
    .phy_rst_n(phy_rst_n), .sub_rst_n(sub_rst_n), .rd_div_lo(rd_div_lo),
    .rd_div_hi(rd_div_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int lo, input int hi, input bit run, input bit en,
                    input bit pg, input bit sg);
    @(negedge clk);
    cfg_we = 1; cfg_div_lo = 3'(lo); cfg_div_hi = 2'(hi);
    cfg_div_run = run; cfg_clk_en = en; cfg_phy_go = pg; cfg_sub_go = sg;
    @(negedge clk);
    cfg_we = 0; cfg_phy_go = 0; cfg_sub_go = 0;
  endtask

  task automatic gap(output int g);
    int w = 0;
    while (!div_tick && w < 64) begin @(negedge clk); w++; end
    g = 1;
    @(negedge clk);
    while (!div_tick && g < 64) begin @(negedge clk); g++; end
  endtask

  task automatic quiet(input string req, input int cyc);
    int seen = 0;
    @(negedge clk);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (div_tick) seen++;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int g, pc, sc;
    bit prev;
    // R9 / R4: held in reset
    repeat (3) @(negedge clk);
    chk("R4 tick in reset", div_tick, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 tick", div_tick, 0);
    chk("R9 phy_rst_n", phy_rst_n, 0);
    chk("R9 sub_rst_n", sub_rst_n, 0);
    chk("R9 rd_div_lo", rd_div_lo, 0);
    chk("R9 rd_div_hi", rd_div_hi, 0);

    // R1 / R2 table walk
    for (int v = 0; v < NV; v++) begin
      wr(V_LO[v], V_HI[v], 0, 0, 0, 0);
      wr(V_LO[v], V_HI[v], 1, 1, 0, 0);
      chk("R2 rd_div_lo", rd_div_lo, V_LO[v]);
      chk("R2 rd_div_hi", rd_div_hi, V_RH[v]);
      gap(g);
      chk("R1 tick period", g, V_N[v]);
    end

    // R3: divide write while running is ignored (last setting N=12)
    wr(6, 0, 1, 1, 0, 0);
    chk("R3 rd_div_lo kept", rd_div_lo, 5);
    chk("R3 rd_div_hi kept", rd_div_hi, 1);
    gap(g);
    chk("R3 period kept", g, 12);

    // R5: enable low stops ticks
    wr(5, 1, 1, 0, 0, 0);
    quiet("R5 no tick with enable low", 40);
    // R4: run low stops ticks even with enable high
    wr(5, 1, 0, 1, 0, 0);
    quiet("R4 no tick with run low", 40);

    // R7 pending: subsystem request first, N=2
    wr(1, 0, 0, 0, 0, 0);
    wr(1, 0, 1, 1, 0, 1);
    repeat (40) @(negedge clk);
    chk("R7 sub pending before phy", sub_rst_n, 0);
    chk("R6 phy held without request", phy_rst_n, 0);

    // R6: phy release after PHY_WAIT ticks
    wr(1, 0, 1, 1, 1, 0);
    pc = 0; prev = 0;
    for (int i = 0; i < 200 && !phy_rst_n; i++) begin
      if (div_tick) pc++;
      prev = div_tick;
      @(negedge clk);
    end
    chk("R6 ticks before phy release", pc, PHY_WAIT);
    chk("R6 tick just before release", prev, 1);

    // R7: sub release after SUB_WAIT ticks with phy released
    sc = 0; prev = 0;
    for (int i = 0; i < 400 && !sub_rst_n; i++) begin
      if (div_tick) sc++;
      prev = div_tick;
      @(negedge clk);
    end
    chk("R7 ticks before sub release", sc, SUB_WAIT);
    chk("R7 tick just before release", prev, 1);

    // R8: sticky against zero writes
    wr(0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk("R8 phy stays released", phy_rst_n, 1);
    chk("R8 sub stays released", sub_rst_n, 1);

    // R9: core reset clears everything
    rst_n = 0;
    @(negedge clk);
    chk("R8 phy cleared by core reset", phy_rst_n, 0);
    chk("R8 sub cleared by core reset", sub_rst_n, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 rd_div_lo after reset", rd_div_lo, 0);
    chk("R9 tick after reset", div_tick, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule